// File: doc/BRIEF.md
# Serial Flash Write-Enable Instruction Front End

This block receives instructions for a serial flash device in SPI mode 0. Chip select frames each instruction. An 8-bit opcode is shifted in most significant bit first, on the rising edges of the serial clock. The block samples both pins with its own system clock, so it sees each edge as a change between two successive clock samples.

The block holds a write-enable latch, an OTP-mode flag, a busy flag and a quad-entry flag. It acts on an instruction only at the rising edge of chip select, and only when exactly one opcode's worth of bits arrived in the frame. Program, erase and status-write opcodes are gated by the latch. Each one that is allowed produces a one-cycle start pulse for the memory core, which later returns a done pulse. The enable-quad opcode switches opcode entry to four lanes, so an opcode then takes two serial clocks.

Top module: `spi_wel_ctl`

## Requirements
- R1: After reset, `status_o`, `quad_o`, `otp_o` and `start_o` are all 0.
- R2: Opcode 06h in a complete frame sets the write-enable latch (`status_o[0]`).
- R3: An instruction acts only at the rising edge of chip select, and only when the frame carried exactly 8 bits. A frame with fewer or more bits is discarded and changes no state.
- R4: Opcode 3Ah sets `otp_o`. Opcode 04h clears the latch and also clears `otp_o`.
- R5: Opcodes 02h, 20h, D8h, C7h and 01h each produce exactly one `start_o` pulse when the latch is set, with `op_o` holding the opcode. The same instruction also sets busy (`status_o[1]`).
- R6: While the latch is clear, the opcodes 02h, 20h, D8h, C7h and 01h are ignored: no start pulse is issued and the status stays the same.
- R7: A `done_i` pulse while busy clears both busy and the latch. A `done_i` pulse while not busy has no effect.
- R8: While busy, every instruction is ignored, including 04h, 06h and the gated opcodes.
- R9: Opcode 38h sets `quad_o`. After that, opcode bits arrive four per serial clock on `sd_i[3:0]`, with `sd_i[3]` the most significant bit and the upper nibble first. Only reset clears quad mode.
- R10: In single-lane mode, bits arrive on `sd_i[0]` most significant bit first. The bit-reversed pattern 60h has no effect.
- R11: `status_o` bit 0 is the latch and bit 1 is busy. Both bits, and `start_o`, change only on system clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sd_i | input | QUAD_LANES | Data lanes; lane 0 is the serial input |
| done_i | input | 1 | Operation-complete pulse from the core |
| start_o | output | 1 | One-cycle start for an allowed operation |
| op_o | output | CODE_BITS | Opcode of the last started operation |
| status_o | output | 2 | {busy, write-enable latch} |
| quad_o | output | 1 | Quad opcode entry active |
| otp_o | output | 1 | OTP mode active |

## Verification
The bench uses the default parameters: 8 opcode bits and 4 quad lanes. With these values a quad opcode takes two serial clocks. A frame of eight quad clocks overshoots to 32 bits, which exercises the rule that discards over-long frames. Short 7-bit frames and long 9-bit frames are also sent in single-lane mode.

// File: rtl/spi_wel_ctl.sv
module spi_wel_ctl #(
  parameter int CODE_BITS  = 8,
  parameter int QUAD_LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic [QUAD_LANES-1:0] sd_i,
  input  logic                  done_i,
  output logic                  start_o,
  output logic [CODE_BITS-1:0]  op_o,
  output logic [1:0]            status_o,
  output logic                  quad_o,
  output logic                  otp_o
);
  localparam int CW = $clog2(CODE_BITS + QUAD_LANES + 1);
  localparam logic [CODE_BITS-1:0] OPC_SET_WE  = CODE_BITS'(8'h06);
  localparam logic [CODE_BITS-1:0] OPC_CLR_WE  = CODE_BITS'(8'h04);
  localparam logic [CODE_BITS-1:0] OPC_OTP_ON  = CODE_BITS'(8'h3A);
  localparam logic [CODE_BITS-1:0] OPC_QUAD_ON = CODE_BITS'(8'h38);
  localparam logic [CODE_BITS-1:0] OPC_PROG    = CODE_BITS'(8'h02);
  localparam logic [CODE_BITS-1:0] OPC_ER_SEC  = CODE_BITS'(8'h20);
  localparam logic [CODE_BITS-1:0] OPC_ER_BLK  = CODE_BITS'(8'hD8);
  localparam logic [CODE_BITS-1:0] OPC_ER_ALL  = CODE_BITS'(8'hC7);
  localparam logic [CODE_BITS-1:0] OPC_WR_STAT = CODE_BITS'(8'h01);

  logic                 sclk_q, cs_q;
  logic [CW-1:0]        cnt;
  logic [CODE_BITS-1:0] shreg;
  logic                 wel, busy, quad, otp, start;

  wire sclk_rise = sclk & ~sclk_q;
  wire cs_rise   = cs_n & ~cs_q;
  wire frame_ok  = cs_rise && (cnt == CW'(CODE_BITS)) && !busy;
  wire gated     = (shreg == OPC_PROG)   || (shreg == OPC_ER_SEC) ||
                   (shreg == OPC_ER_BLK) || (shreg == OPC_ER_ALL) ||
                   (shreg == OPC_WR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        cnt <= '0;
      end else if (sclk_rise && cnt <= CW'(CODE_BITS)) begin
        if (quad) begin
          cnt   <= cnt + CW'(QUAD_LANES);
          shreg <= {shreg[CODE_BITS-QUAD_LANES-1:0], sd_i};
        end else begin
          cnt   <= cnt + CW'(1);
          shreg <= {shreg[CODE_BITS-2:0], sd_i[0]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      busy  <= 1'b0;
      quad  <= 1'b0;
      otp   <= 1'b0;
      start <= 1'b0;
      op_o  <= '0;
    end else begin
      start <= 1'b0;
      if (busy && done_i) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else if (frame_ok) begin
        if (shreg == OPC_SET_WE) wel <= 1'b1;
        if (shreg == OPC_CLR_WE) begin
          wel <= 1'b0;
          otp <= 1'b0;
        end
        if (shreg == OPC_OTP_ON)  otp  <= 1'b1;
        if (shreg == OPC_QUAD_ON) quad <= 1'b1;
        if (gated && wel) begin
          busy  <= 1'b1;
          start <= 1'b1;
          op_o  <= shreg;
        end
      end
    end
  end

  assign start_o  = start;
  assign status_o = {busy, wel};
  assign quad_o   = quad;
  assign otp_o    = otp;
endmodule

// File: rtl/spi_wel_ctl_chk.sv
module spi_wel_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       done_i,
  input logic       start_o,
  input logic [1:0] status_o,
  input logic       quad_o
);
  p_start_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(status_o[0]));
  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  p_start_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> status_o[1]);
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(status_o[1]));
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && status_o[1]) |=> (status_o == 2'b00));
  p_wel_at_cs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> cs_n);
  p_quad_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quad_o |=> quad_o);
endmodule

bind spi_wel_ctl spi_wel_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .done_i(done_i),
  .start_o(start_o), .status_o(status_o), .quad_o(quad_o)
);

// File: tb/test_spi_wel_ctl.sv
`timescale 1ns/1ps
module test_spi_wel_ctl;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, done_i = 1'b0;
  logic [3:0] sd_i = '0;
  logic start_o, quad_o, otp_o;
  logic [7:0] op_o;
  logic [1:0] status_o;
  int checks = 0, failures = 0;
  logic seen_start, extra_start;
  logic [7:0] seen_op;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_wel_ctl i_spi_wel_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sd_i(sd_i),
    .done_i(done_i), .start_o(start_o), .op_o(op_o), .status_o(status_o),
    .quad_o(quad_o), .otp_o(otp_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] code, input int nclk, input bit q);
    logic [15:0] v = {code, 8'h00};
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk);
      if (q) begin sd_i = v[15:12]; v = v << 4; end
      else begin sd_i = {3'b000, v[15]}; v = v << 1; end
      @(negedge clk) sclk = 1'b1;
      @(negedge clk) sclk = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    seen_start = start_o;
    seen_op = op_o;
    @(negedge clk);
    extra_start = start_o;
  endtask

  task automatic op(input logic [7:0] code);
    frame(code, quad_o ? 2 : 8, quad_o);
  endtask

  task automatic pulse_done;
    @(negedge clk) done_i = 1'b1;
    @(negedge clk) done_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", status_o, 0);
    chk("R1 quad", quad_o, 0);
    chk("R1 otp", otp_o, 0);
    chk("R1 start", start_o, 0);
  endtask

  task automatic t_gate_rejected;
    logic [7:0] g [5] = '{8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01};
    foreach (g[k]) begin
      op(g[k]);
      chk("R6 no start", seen_start, 0);
      chk("R6 status", status_o, 0);
    end
  endtask

  task automatic t_frames;
    frame(8'h06, 7, 0);
    chk("R3 short frame", status_o, 0);
    frame(8'h06, 9, 0);
    chk("R3 long frame", status_o, 0);
    op(8'h60);
    chk("R10 reversed bits", status_o, 0);
    op(8'h06);
    chk("R2 wel set", status_o, 1);
    frame(8'h04, 7, 0);
    chk("R3 short clear ignored", status_o, 1);
    op(8'h04);
    chk("R10 clear", status_o, 0);
  endtask

  task automatic t_otp;
    op(8'h3A);
    chk("R4 otp on", otp_o, 1);
    op(8'h06);
    op(8'h04);
    chk("R4 wel cleared", status_o, 0);
    chk("R4 otp cleared", otp_o, 0);
  endtask

  task automatic t_gated_ok;
    logic [7:0] g [5] = '{8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01};
    foreach (g[k]) begin
      op(8'h06);
      op(g[k]);
      chk("R5 start", seen_start, 1);
      chk("R5 single pulse", extra_start, 0);
      chk("R5 op", seen_op, g[k]);
      chk("R11 busy and wel", status_o, 3);
      op(8'h04);
      chk("R8 clear ignored", status_o, 3);
      op(8'h20);
      chk("R8 no second start", seen_start, 0);
      pulse_done;
      chk("R7 done clears", status_o, 0);
    end
    op(8'h06);
    pulse_done;
    chk("R7 idle done ignored", status_o, 1);
    op(8'h04);
  endtask

  task automatic t_quad;
    op(8'h38);
    chk("R9 quad on", quad_o, 1);
    frame(8'h06, 2, 1);
    chk("R9 quad set wel", status_o, 1);
    frame(8'h04, 8, 1);
    chk("R3 quad overlong", status_o, 1);
    frame(8'h04, 2, 1);
    chk("R9 quad clear wel", status_o, 0);
    frame(8'h60, 2, 1);
    chk("R9 nibble order", status_o, 0);
    frame(8'h04, 2, 1);
    chk("R9 quad sticky", quad_o, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_gate_rejected;
    t_frames;
    t_otp;
    t_gated_ok;
    t_quad;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule